// File: doc/BRIEF.md
# Interrupt Cause, Mask and Throttle Controller

This block collects interrupt causes posted by internal sources into a 31-bit cause register and drives one level interrupt line to the host. A mask register selects which causes may raise the line. A throttle interval, counted in 256 ns ticks derived from the core clock, spaces out line assertions: non-urgent posts arm a one-shot hold timer instead of raising the line at once. Bit 31 of the visible cause word is the asserted flag, and it is the line itself.

The host side is a set of single-cycle strobes sharing one write-data bus. There is a cause read (read-to-clear), a cause write (write-one-to-clear), a cause-set write, mask set and mask clear writes, an auto-mask register write and an interval write. An auto-mask enable level makes cause reads and writes also knock selected bits out of the mask. Sources post a cause vector with an optional immediate flag. A post whose vector overlaps a cause that is already pending is dropped unless it is immediate. In any cycle the register strobe takes effect first, then the cause-set write and the source post, then a timer expiry.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset the cause word, the mask, the auto-mask, the interval and the line are all zero.
- R2: A post ORs its vector into cause bits 30:0. When the interval is zero, the line rises on the clock edge that takes the post if the enabled set (cause AND mask) is non-zero.
- R3: A non-immediate post whose vector shares any bit with the pending cause bits is dropped whole. No cause bit changes and no timer starts.
- R4: With interval N greater than zero, a non-immediate post starts the hold timer only if it is idle. The line rises N×256 ns later, which is N×32 clocks at the default 125 MHz, counted from the post edge. Later posts do not restart the timer.
- R5: An immediate post cancels any running timer and evaluates assertion at once, whatever the interval. After that, the next throttled post waits a full interval.
- R6: A cause outside the mask is recorded but never raises the line.
- R7: The cause port shows the flag in bit 31 and the causes in bits 30:0. A read clears bits 30:0 when the flag is set or the mask is zero, and keeps them otherwise.
- R8: A read taken while the flag is set and auto-mask is enabled clears the mask bits that the auto-mask register selects. A read taken with the flag clear leaves the mask unchanged.
- R9: A cause write clears the cause bits 30:0 written as one. Bit 31 of the data has no effect. With auto-mask enabled, the write also clears the auto-mask-selected mask bits, whatever the flag.
- R10: A cause-set write posts its data bits 30:0 as a non-immediate post.
- R11: After a cause read, a cause write, a mask set or a mask clear, an empty enabled set drops the line and cancels the timer. Otherwise the line asserts at once when the interval is zero, or the timer starts if it is idle.
- R12: The line equals bit 31 of the cause port in every cycle.
- R13: At most one register strobe is active per cycle. A source post in the same cycle as a cause read is applied after the read's clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_vld_i | input | 1 | Source post request |
| post_cause_i | input | 31 | Cause vector of the post |
| post_now_i | input | 1 | Post bypasses throttling and duplicate filter |
| wdata_i | input | 32 | Register write data |
| rd_cause_i | input | 1 | Cause read strobe |
| wr_cause_i | input | 1 | Cause write-one-to-clear strobe |
| wr_cause_set_i | input | 1 | Cause set strobe |
| wr_mask_set_i | input | 1 | Mask set strobe |
| wr_mask_clr_i | input | 1 | Mask clear strobe |
| wr_automask_i | input | 1 | Auto-mask register write strobe |
| wr_ivl_i | input | 1 | Throttle interval write strobe (data bits 15:0) |
| automask_en_i | input | 1 | Auto-mask enable level |
| cause_o | output | 32 | Asserted flag (bit 31) and cause bits 30:0 |
| mask_o | output | 31 | Current mask |
| irq_o | output | 1 | Level interrupt line |

## Verification
A stale cause bit or a missed clear shows on cause_o on the clock after the offending strobe. A corrupted mask shows on mask_o on that same clock, and the line follows one edge later. Faults in the hold timer show only after a throttled post: an early or late rise, or a rise that should have been cancelled, appears anywhere in a window of one to N×32 clocks. The bench therefore watches the line every cycle across whole intervals, not only at their end points. Line and flag are compared every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NS_PER_TICK = 256;

  function automatic int unsigned tick_cycles(int unsigned clk_mhz);
    int unsigned c;
    c = (clk_mhz * NS_PER_TICK + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int unsigned TICK_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  output logic tick_o
);
  if (TICK_CYC <= 1) begin : g_direct
    logic unused_direct;
    assign unused_direct = ^{restart_i, clk_i, rst_ni};
    assign tick_o = en_i;
  end else begin : g_count
    localparam int unsigned PRE_W = $clog2(TICK_CYC);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYC - 1);
    logic [PRE_W-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == PRE_LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (en_i)      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(cnt_q) < TICK_CYC); // R4
  end
endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
  parameter int unsigned TICK_CYC = 32,
  parameter int unsigned IVL_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             run_o,
  output logic             exp_o
);
  logic             run_q;
  logic [IVL_W-1:0] ticks_q;
  logic [IVL_W-1:0] ivl_q;
  logic             tick;

  irq_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .en_i      (run_q),
    .tick_o    (tick)
  );

  assign exp_o = run_q && tick && (ticks_q == ivl_q - IVL_W'(1));
  assign run_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ticks_q <= '0;
      ivl_q   <= '0;
    end else if (load_i) begin
      run_q   <= 1'b1;
      ticks_q <= '0;
      ivl_q   <= ivl_i;
    end else if (kill_i || exp_o) begin
      run_q   <= 1'b0;
      ticks_q <= '0;
    end else if (tick) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  AST_TICKS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ticks_q < ivl_q)); // R4
  AST_IVL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ivl_q != '0)); // R4
endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_MHZ = 125,
  parameter int unsigned CAUSE_W      = 31,
  parameter int unsigned IVL_W        = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               post_vld_i,
  input  logic [CAUSE_W-1:0] post_cause_i,
  input  logic               post_now_i,
  input  logic [CAUSE_W:0]   wdata_i,
  input  logic               rd_cause_i,
  input  logic               wr_cause_i,
  input  logic               wr_cause_set_i,
  input  logic               wr_mask_set_i,
  input  logic               wr_mask_clr_i,
  input  logic               wr_automask_i,
  input  logic               wr_ivl_i,
  input  logic               automask_en_i,
  output logic [CAUSE_W:0]   cause_o,
  output logic [CAUSE_W-1:0] mask_o,
  output logic               irq_o
);
  localparam int unsigned TICK_CYC = tick_cycles(CLK_FREQ_MHZ);
  localparam int unsigned NSRC     = 2;

  logic [CAUSE_W-1:0] cause_q, cause_v;
  logic               flag_q, flag_v;
  logic [CAUSE_W-1:0] mask_q, mask_v;
  logic [CAUSE_W-1:0] am_q, am_v;
  logic [IVL_W-1:0]   ivl_q, ivl_v;
  logic               run_v, tmr_load, tmr_kill, recheck;
  logic               tmr_run, tmr_exp;
  logic               src_vld [NSRC];
  logic               src_now [NSRC];
  logic [CAUSE_W-1:0] src_cause [NSRC];
  logic [CAUSE_W-1:0] wd;
  logic               any_op;
  logic               unused_wdata;

  assign wd           = wdata_i[CAUSE_W-1:0];
  assign unused_wdata = wdata_i[CAUSE_W];
  assign any_op       = rd_cause_i | wr_cause_i | wr_cause_set_i | wr_mask_set_i |
                        wr_mask_clr_i | wr_automask_i | wr_ivl_i;

  // source 0: cause-set write, source 1: internal post
  assign src_vld[0]   = wr_cause_set_i;
  assign src_now[0]   = 1'b0;
  assign src_cause[0] = wd;
  assign src_vld[1]   = post_vld_i;
  assign src_now[1]   = post_now_i;
  assign src_cause[1] = post_cause_i;

  always_comb begin
    cause_v  = cause_q;
    flag_v   = flag_q;
    mask_v   = mask_q;
    am_v     = am_q;
    ivl_v    = ivl_q;
    run_v    = tmr_run;
    tmr_load = 1'b0;
    tmr_kill = 1'b0;
    recheck  = 1'b0;

    // register operation
    if (rd_cause_i) begin
      if (flag_q && automask_en_i) mask_v = mask_v & ~am_q;
      if (flag_q || (mask_q == '0)) cause_v = '0;
      recheck = 1'b1;
    end else if (wr_cause_i) begin
      if (automask_en_i) mask_v = mask_v & ~am_q;
      cause_v = cause_v & ~wd;
      recheck = 1'b1;
    end else if (wr_mask_set_i) begin
      mask_v  = mask_v | wd;
      recheck = 1'b1;
    end else if (wr_mask_clr_i) begin
      mask_v  = mask_v & ~wd;
      recheck = 1'b1;
    end else if (wr_automask_i) begin
      am_v = wd;
    end else if (wr_ivl_i) begin
      ivl_v = wdata_i[IVL_W-1:0];
    end

    if (recheck) begin
      if ((cause_v & mask_v) == '0) begin
        flag_v   = 1'b0;
        run_v    = 1'b0;
        tmr_kill = 1'b1;
        tmr_load = 1'b0;
      end else if (ivl_v == '0) begin
        flag_v   = 1'b1;
        run_v    = 1'b0;
        tmr_kill = 1'b1;
        tmr_load = 1'b0;
      end else if (!run_v) begin
        run_v    = 1'b1;
        tmr_load = 1'b1;
      end
    end

    // posts
    for (int s = 0; s < NSRC; s++) begin
      if (src_vld[s] && !(((src_cause[s] & cause_v) != '0) && !src_now[s])) begin
        cause_v = cause_v | src_cause[s];
        if ((ivl_v == '0) || src_now[s]) begin
          run_v    = 1'b0;
          tmr_kill = 1'b1;
          tmr_load = 1'b0;
          if ((cause_v & mask_v) != '0) flag_v = 1'b1;
        end else if (!run_v) begin
          run_v    = 1'b1;
          tmr_load = 1'b1;
        end
      end
    end

    // throttle expiry
    if (tmr_exp && !tmr_kill && !tmr_load) begin
      if ((cause_v & mask_v) != '0) flag_v = 1'b1;
    end
  end

  irq_hold_timer #(.TICK_CYC(TICK_CYC), .IVL_W(IVL_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .kill_i (tmr_kill),
    .ivl_i  (ivl_v),
    .run_o  (tmr_run),
    .exp_o  (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      flag_q  <= 1'b0;
      mask_q  <= '0;
      am_q    <= '0;
      ivl_q   <= '0;
    end else begin
      cause_q <= cause_v;
      flag_q  <= flag_v;
      mask_q  <= mask_v;
      am_q    <= am_v;
      ivl_q   <= ivl_v;
    end
  end

  assign cause_o = {flag_q, cause_q};
  assign mask_o  = mask_q;
  assign irq_o   = flag_q;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_cause_i, wr_cause_i, wr_cause_set_i, wr_mask_set_i,
              wr_mask_clr_i, wr_automask_i, wr_ivl_i})); // R13
  AST_FLAG_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> ((cause_q & mask_q) != '0)); // R11
  AST_IMM_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_vld_i && post_now_i && !any_op && (((cause_q | post_cause_i) & mask_q) != '0))
    |=> irq_o); // R5
  AST_RTC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cause_i && flag_q && !post_vld_i) |=> ((cause_q == '0) && !irq_o)); // R7
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cause_i && !post_vld_i) |=> ((cause_q & $past(wd)) == '0)); // R9
  AST_DUP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_vld_i && !post_now_i && !any_op && ((post_cause_i & cause_q) != '0))
    |=> (cause_q == $past(cause_q))); // R3
  AST_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask_clr_i && !post_vld_i && ((cause_q & mask_q & ~wd) == '0)) |=> !irq_o); // R11
endmodule

// File: tb/irq_throttle_ctrl_bench.sv
module irq_throttle_ctrl_bench;
  localparam int OP_RD = 0, OP_WC = 1, OP_SET = 2, OP_MS = 3, OP_MC = 4, OP_AM = 5, OP_IVL = 6;
  localparam int TK = 32; // clocks per 256 ns at 125 MHz

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        post_vld = 1'b0, post_now = 1'b0;
  logic [30:0] post_cause = '0;
  logic [31:0] wdata = '0;
  logic        rd_c = 0, wr_c = 0, wr_s = 0, wr_ms = 0, wr_mc = 0, wr_am = 0, wr_iv = 0;
  logic        am_en = 1'b0;
  logic [31:0] cause_o;
  logic [30:0] mask_o;
  logic        irq_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irq_throttle_ctrl u_irq_throttle_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .post_vld_i(post_vld), .post_cause_i(post_cause),
    .post_now_i(post_now), .wdata_i(wdata), .rd_cause_i(rd_c), .wr_cause_i(wr_c),
    .wr_cause_set_i(wr_s), .wr_mask_set_i(wr_ms), .wr_mask_clr_i(wr_mc),
    .wr_automask_i(wr_am), .wr_ivl_i(wr_iv), .automask_en_i(am_en),
    .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R12 line tracks flag every cycle
  always @(negedge clk) if (rst_ni && !done) chk("R12", {31'd0, irq_o}, {31'd0, cause_o[31]});

  task automatic op(input int kind, input logic [31:0] d);
    wdata = d;
    case (kind)
      OP_RD:  rd_c  = 1'b1;
      OP_WC:  wr_c  = 1'b1;
      OP_SET: wr_s  = 1'b1;
      OP_MS:  wr_ms = 1'b1;
      OP_MC:  wr_mc = 1'b1;
      OP_AM:  wr_am = 1'b1;
      default: wr_iv = 1'b1;
    endcase
    @(negedge clk);
    {rd_c, wr_c, wr_s, wr_ms, wr_mc, wr_am, wr_iv} = '0;
    wdata = '0;
  endtask

  task automatic post(input logic [30:0] c, input logic now);
    post_vld = 1'b1; post_cause = c; post_now = now;
    @(negedge clk);
    post_vld = 1'b0; post_cause = '0; post_now = 1'b0;
  endtask

  task automatic hold_low(input int n, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq_o) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cause_o, 32'h0);
    chk("R1", {1'b0, mask_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, irq_o}, 32'h0);

    // sweep: every cause bit against alternating mask, interval zero
    op(OP_MS, 32'h5555_5555);
    for (int b = 0; b < 31; b++) begin
      logic en;
      en = (b % 2) == 0;
      post(31'(1) << b, 1'b0);
      chk("R2", cause_o, {en, 31'(1) << b});
      op(OP_RD, 0);
      chk("R7", cause_o, en ? 32'h0 : {1'b0, 31'(1) << b});
      op(OP_WC, 32'(1) << b);
      chk("R9", cause_o, 32'h0);
    end

    // mask zero: read clears, masked cause recorded
    op(OP_MC, 32'h7FFF_FFFF);
    post(31'h8, 1'b0);
    chk("R6", cause_o, 32'h0000_0008);
    op(OP_RD, 0);
    chk("R7", cause_o, 32'h0);

    // duplicate filter and immediate bypass
    op(OP_MS, 32'h2);
    post(31'h2, 1'b0);
    chk("R2", cause_o, 32'h8000_0002);
    post(31'h12, 1'b0);
    chk("R3", cause_o, 32'h8000_0002);
    post(31'h12, 1'b1);
    chk("R5", cause_o, 32'h8000_0012);
    op(OP_RD, 0);
    chk("R7", cause_o, 32'h0);

    // throttled assertion, no restart by later post
    op(OP_IVL, 32'd2);
    op(OP_MS, 32'h1);
    post(31'h1, 1'b0);
    repeat (19) @(negedge clk);
    post(31'h2, 1'b0);
    hold_low(2*TK - 21, "R4");
    chk("R4", cause_o, 32'h0000_0003);
    @(negedge clk);
    chk("R4", cause_o, 32'h8000_0003);
    op(OP_RD, 0);

    // immediate post cancels running timer
    post(31'h1, 1'b0);
    repeat (9) @(negedge clk);
    post(31'h20, 1'b1);
    chk("R5", cause_o, 32'h8000_0021);
    op(OP_RD, 0);
    chk("R7", cause_o, 32'h0);
    post(31'h1, 1'b0);
    hold_low(2*TK - 1, "R5");
    @(negedge clk);
    chk("R5", {31'd0, irq_o}, 32'h1);
    op(OP_RD, 0);

    // cause-set write
    op(OP_IVL, 32'd0);
    op(OP_MS, 32'h3);
    op(OP_SET, 32'h1);
    chk("R10", cause_o, 32'h8000_0001);
    op(OP_SET, 32'h3);
    chk("R10", cause_o, 32'h8000_0001);
    op(OP_RD, 0);
    chk("R7", cause_o, 32'h0);

    // auto-mask
    am_en = 1'b1;
    op(OP_AM, 32'h0F);
    op(OP_MS, 32'hFF);
    post(31'h10, 1'b0);
    chk("R2", cause_o, 32'h8000_0010);
    op(OP_RD, 0);
    chk("R8", {1'b0, mask_o}, 32'hF0);
    chk("R7", cause_o, 32'h0);
    post(31'h1, 1'b0);
    op(OP_RD, 0);
    chk("R8", {1'b0, mask_o}, 32'hF0);
    chk("R7", cause_o, 32'h0000_0001);
    op(OP_WC, 32'h1);
    op(OP_MS, 32'h0F);
    chk("R9", {1'b0, mask_o}, 32'hFF);
    op(OP_WC, 32'h0);
    chk("R9", {1'b0, mask_o}, 32'hF0);
    post(31'h60, 1'b0);
    op(OP_WC, 32'h8000_0020);
    chk("R9", cause_o, 32'h8000_0040);
    am_en = 1'b0;

    // mask changes
    op(OP_MC, 32'h40);
    chk("R11", cause_o, 32'h0000_0040);
    op(OP_MS, 32'h40);
    chk("R11", cause_o, 32'h8000_0040);
    op(OP_MC, 32'h40);
    op(OP_IVL, 32'd1);
    op(OP_MS, 32'h40);
    hold_low(TK - 1, "R11");
    @(negedge clk);
    chk("R11", {31'd0, irq_o}, 32'h1);
    op(OP_MC, 32'h40);
    chk("R11", {31'd0, irq_o}, 32'h0);
    op(OP_MS, 32'h40);
    repeat (4) @(negedge clk);
    op(OP_MC, 32'h40);
    repeat (4) @(negedge clk);
    op(OP_MS, 32'h40);
    hold_low(TK - 1, "R11");
    @(negedge clk);
    chk("R11", {31'd0, irq_o}, 32'h1);

    // read and post in the same cycle
    op(OP_MC, 32'h7FFF_FFFF);
    op(OP_IVL, 32'd0);
    chk("R6", cause_o, 32'h0000_0040);
    post_vld = 1'b1; post_cause = 31'h80; rd_c = 1'b1;
    @(negedge clk);
    post_vld = 1'b0; post_cause = '0; rd_c = 1'b0;
    chk("R13", cause_o, 32'h0000_0080);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule